// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit control and status words for a system controller. A simple word-addressed bus reaches it, with one request per cycle. Word zero holds a protection key. Most of the low half of the map accepts writes only while that key holds a fixed 32-bit magic value. The words from byte offset 0x104 upward accept writes at any time. A handful of status words ignore writes. One word is meant only to be written. Three words take their reset value from external revision and strap inputs rather than from a constant.

Every request is classified before it touches storage. The classes are: good, locked write, write to a read-only word, read of the write-only word, out-of-range index, and unaligned address. A good write lands on the clock edge that accepts it. Every other write is dropped. Reads return registered data one cycle after the request. Any rejected or misused access raises a one-cycle error pulse that is aligned with its response.

A two-state response machine sequences the bus:
- IDLE goes to RESP when a request is accepted, and stays in IDLE otherwise.
- RESP goes back to RESP on a back-to-back request, and to IDLE when no request arrives.
- The response-valid output is high exactly while the machine is in RESP.

Top module: `scr_ctrl_regs`

## Requirements
- R1: After reset, the key word at byte offset 0x000 reads 0, so the block starts locked. Fixed defaults also load: 0x004 reads 0xFFCFFEDC, 0x00C reads 0x19FC3E8B, 0x040 reads 0x000000C0 and 0x074 reads 0x0000000E. Every other word without an input-driven default reads 0.
- R2: Reset loads offset 0x07C from `rev_in`, offset 0x070 from `strap_a` and offset 0x0D0 from `strap_b`.
- R3: A request accepted on edge N gives `bus_rvalid` high for the cycle after edge N, with read data valid in that cycle. A write is visible to a read issued in the very next cycle.
- R4: The block is unlocked only while the key word equals 0x1688A8A8. Writes to the key word are always accepted without error, locked or not, and the key word reads back what was written.
- R5: While locked, a write to an aligned offset from 0x004 through 0x100 is discarded and raises `bus_err`.
- R6: Offsets from 0x104 up to the end of the array accept writes without error, even while locked.
- R7: Writes to offsets 0x014, 0x050–0x06C, 0x078, 0x07C, 0x0E0 and 0x0E4 are discarded and raise `bus_err`, even while unlocked.
- R8: Offset 0x0C0 is write-only. A write to it succeeds without error. A read of it raises `bus_err` but still returns the stored value.
- R9: An aligned access whose word index is NUM_REGS or more (offset 0x1A8 and up by default) raises `bus_err`. Such a read returns 0, and such a write changes nothing.
- R10: An address with either of bits [1:0] set raises `bus_err`. Such a read returns 0, and such a write changes nothing.
- R11: `bus_err` lasts exactly one cycle, is high only together with `bus_rvalid`, and stays low for accepted accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| rev_in | input | 32 | Revision value loaded at reset |
| strap_a | input | 32 | First strap value loaded at reset |
| strap_b | input | 32 | Second strap value loaded at reset |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Response for the request of the previous cycle |
| bus_err | output | 1 | One-cycle pulse for a rejected or misused access |

## Verification
A wrong key comparison or lock window shows up on the next response. It appears as an error pulse where none is due, or a missing one, and then as a stale or altered word on the next read of the same offset, at the earliest one cycle later. A misdecoded read-only, write-only or range class shows the same pattern. A response machine stuck in the wrong state shows at once as a response-valid pulse with no matching request, or a request with no response. For that reason the expected queue is compared every cycle.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam logic [31:0] SCR_UNLOCK_KEY = 32'h1688_A8A8;

    // word indices (byte offset >> 2)
    localparam int IDX_KEY      = 0;
    localparam int LOCK_FIRST   = 1;
    localparam int LOCK_LAST    = 64;
    localparam int IDX_FCNT_RES = 5;
    localparam int SCRATCH_LO   = 20;
    localparam int SCRATCH_HI   = 27;
    localparam int IDX_STRAP_A  = 28;
    localparam int IDX_RAND     = 30;
    localparam int IDX_REV      = 31;
    localparam int IDX_WONLY    = 48;
    localparam int IDX_STRAP_B  = 52;
    localparam int IDX_FREE_LO  = 56;
    localparam int IDX_FREE_HI  = 57;

    typedef enum logic [2:0] {
        ACC_OK,
        ACC_LOCKED,
        ACC_RDONLY,
        ACC_WRONLY,
        ACC_RANGE,
        ACC_ALIGN
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    function automatic logic is_readonly(int i);
        return (i == IDX_FCNT_RES) || (i >= SCRATCH_LO && i <= SCRATCH_HI) ||
               (i == IDX_RAND) || (i == IDX_REV) ||
               (i == IDX_FREE_LO) || (i == IDX_FREE_HI);
    endfunction

    function automatic logic is_writeonly(int i);
        return i == IDX_WONLY;
    endfunction

    function automatic logic in_lock_window(int i);
        return (i >= LOCK_FIRST) && (i <= LOCK_LAST);
    endfunction

    function automatic logic [31:0] fixed_default(int i);
        case (i)
            1:       return 32'hFFCF_FEDC;
            3:       return 32'h19FC_3E8B;
            16:      return 32'h0000_00C0;
            29:      return 32'h0000_000E;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/scr_decode.sv
module scr_decode
    import scr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106,
    parameter int IW       = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              unlocked,
    output acc_kind_e         kind,
    output logic [IW-1:0]     idx
);

    always_comb begin
        idx  = addr[ADDR_W-1:2];
        kind = ACC_OK;
        if (addr[1:0] != 2'b00) begin
            kind = ACC_ALIGN;
        end else if (int'(idx) >= NUM_REGS) begin
            kind = ACC_RANGE;
        end else if (we) begin
            if (in_lock_window(int'(idx)) && !unlocked) begin
                kind = ACC_LOCKED;
            end else if (is_readonly(int'(idx))) begin
                kind = ACC_RDONLY;
            end
        end else if (is_writeonly(int'(idx))) begin
            kind = ACC_WRONLY;
        end
    end

endmodule

// File: rtl/scr_keyguard.sv
module scr_keyguard
    import scr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] key_q,
    output logic        unlocked
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (wr_en) begin
            key_q <= wr_data;
        end
    end

    assign unlocked = (key_q == SCR_UNLOCK_KEY);

    // R4: writing the magic value opens the block on the next cycle
    a_r4_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == SCR_UNLOCK_KEY) |=> unlocked);

    // R4: without a key write, the lock state cannot move
    a_r4_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(key_q));

endmodule

// File: rtl/scr_bank.sv
module scr_bank
    import scr_pkg::*;
#(
    parameter int NUM_REGS = 106,
    parameter int IW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    input  logic [31:0]   rev_in,
    input  logic [31:0]   strap_a,
    input  logic [31:0]   strap_b
);

    logic [31:0] word_w [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == IDX_KEY) begin : g_hole
            // the key word lives in the key guard
            assign word_w[i] = '0;
        end else begin : g_reg
            logic [31:0] rst_val;
            logic [31:0] q;
            if (i == IDX_REV) begin : g_rev
                assign rst_val = rev_in;
            end else if (i == IDX_STRAP_A) begin : g_sa
                assign rst_val = strap_a;
            end else if (i == IDX_STRAP_B) begin : g_sb
                assign rst_val = strap_b;
            end else begin : g_fix
                assign rst_val = fixed_default(i);
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= rst_val;
                end else if (wr_en && wr_idx == IW'(i)) begin
                    q <= wr_data;
                end
            end
            assign word_w[i] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = word_w[i];
            end
        end
    end

    // R7: a read-only word is never offered a store
    a_r7_no_ro_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !is_readonly(int'(wr_idx)));

endmodule

// File: rtl/scr_ctrl_regs.sv
module scr_ctrl_regs
    import scr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       rev_in,
    input  logic [31:0]       strap_a,
    input  logic [31:0]       strap_b,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err
);

    localparam int IW = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] LOCK_LO_B  = ADDR_W'(LOCK_FIRST * 4);
    localparam logic [ADDR_W-1:0] LOCK_END_B = ADDR_W'((LOCK_LAST + 1) * 4);
    localparam logic [ADDR_W-1:0] RANGE_B    = ADDR_W'(NUM_REGS * 4);

    acc_kind_e     kind;
    logic [IW-1:0] idx;
    logic          unlocked;
    logic [31:0]   key_q;
    logic [31:0]   bank_rdata;
    logic          wr_ok, wr_key, wr_bank;
    logic [31:0]   rd_val;
    bus_state_e    state_q, state_d;
    logic [31:0]   rdata_q;
    logic          err_q;

    scr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IW(IW)) dec_i (
        .addr     (bus_addr),
        .we       (bus_we),
        .unlocked (unlocked),
        .kind     (kind),
        .idx      (idx)
    );

    assign wr_ok   = bus_req && bus_we && (kind == ACC_OK);
    assign wr_key  = wr_ok && (idx == IW'(IDX_KEY));
    assign wr_bank = wr_ok && (idx != IW'(IDX_KEY));

    scr_keyguard key_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_key),
        .wr_data  (bus_wdata),
        .key_q    (key_q),
        .unlocked (unlocked)
    );

    scr_bank #(.NUM_REGS(NUM_REGS), .IW(IW)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_bank),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .rd_idx  (idx),
        .rd_data (bank_rdata),
        .rev_in  (rev_in),
        .strap_a (strap_a),
        .strap_b (strap_b)
    );

    always_comb begin
        rd_val = '0;
        if (kind == ACC_OK || kind == ACC_WRONLY) begin
            rd_val = (idx == IW'(IDX_KEY)) ? key_q : bank_rdata;
        end
    end

    // response state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = bus_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = bus_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= (bus_req && !bus_we) ? rd_val : '0;
            err_q   <= bus_req && (kind != ACC_OK);
        end
    end

    assign bus_rvalid = (state_q == ST_RESP);
    assign bus_rdata  = rdata_q;
    assign bus_err    = err_q;

    // R3: every request is answered on the next cycle
    a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_rvalid);

    // R11: an error only ever rides on a response
    a_r11_err_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rvalid);

    // R5: locked writes inside the window are flagged
    a_r5_locked_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !unlocked && bus_addr[1:0] == 2'b00 &&
         bus_addr >= LOCK_LO_B && bus_addr < LOCK_END_B) |=> bus_err);

    // R9: out-of-range reads give zero with an error
    a_r9_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr >= RANGE_B) |=> (bus_err && bus_rdata == '0));

endmodule

// File: tb/scr_ctrl_regs_tb.sv
`timescale 1ns/1ps
module scr_ctrl_regs_tb_top;

    localparam logic [31:0] REV = 32'hA5C3_0011;
    localparam logic [31:0] SA  = 32'h1234_5678;
    localparam logic [31:0] SB  = 32'h0BAD_F00D;
    localparam logic [31:0] KEY = 32'h1688_A8A8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        bus_err;

    int n_cmp = 0;
    int n_bad = 0;

    bit          chk_q[$];
    logic [31:0] dat_q[$];
    bit          err_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    scr_ctrl_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rev_in     (REV),
        .strap_a    (SA),
        .strap_b    (SB),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err)
    );

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rvalid) begin
                n_cmp++;
                if (tag_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R3 unexpected response: actual rvalid=1 expected rvalid=0");
                end else begin
                    automatic bit          c = chk_q.pop_front();
                    automatic logic [31:0] d = dat_q.pop_front();
                    automatic bit          e = err_q.pop_front();
                    automatic string       t = tag_q.pop_front();
                    if ((c && bus_rdata !== d) || bus_err !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                                 t, bus_rdata, bus_err, c ? d : bus_rdata, e);
                    end
                end
            end else if (bus_err) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R11 err without response: actual err=1 expected err=0");
            end
        end
    end

    task automatic acc(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input bit chk, input logic [31:0] exp_d, input bit exp_e,
                       input string tag);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        chk_q.push_back(chk);
        dat_q.push_back(exp_d);
        err_q.push_back(exp_e);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit e, input string tag);
        acc(1'b1, a, d, 1'b0, '0, e, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] d, input bit e, input string tag);
        acc(1'b0, a, '0, 1'b1, d, e, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: no response activity during or right after reset
        n_cmp++;
        if (bus_rvalid !== 1'b0 || bus_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual rvalid=%b err=%b expected 0 0", bus_rvalid, bus_err);
        end
        rst_n = 1'b1;
        idle(1);

        rd(12'h000, 32'h0, 1'b0, "R1 key zero");
        rd(12'h004, 32'hFFCF_FEDC, 1'b0, "R1 default 0x004");
        rd(12'h00C, 32'h19FC_3E8B, 1'b0, "R1 default 0x00C");
        rd(12'h040, 32'h0000_00C0, 1'b0, "R1 default 0x040");
        rd(12'h074, 32'h0000_000E, 1'b0, "R1 default 0x074");
        rd(12'h008, 32'h0, 1'b0, "R1 unlisted zero");
        rd(12'h07C, REV, 1'b0, "R2 revision");
        rd(12'h070, SA, 1'b0, "R2 strap a");
        rd(12'h0D0, SB, 1'b0, "R2 strap b");

        wr(12'h040, 32'h55, 1'b1, "R5 locked write");
        rd(12'h040, 32'h0000_00C0, 1'b0, "R5 locked word kept");
        wr(12'h100, 32'h1, 1'b1, "R5 window top");
        rd(12'h100, 32'h0, 1'b0, "R5 window top kept");

        wr(12'h104, 32'hDEAD_BEEF, 1'b0, "R6 write above window");
        rd(12'h104, 32'hDEAD_BEEF, 1'b0, "R6 R3 readback");

        wr(12'h000, 32'h1688_A8A9, 1'b0, "R4 wrong key write");
        rd(12'h000, 32'h1688_A8A9, 1'b0, "R4 key readback");
        wr(12'h044, 32'h77, 1'b1, "R4 wrong key stays locked");

        wr(12'h000, KEY, 1'b0, "R4 magic key");
        wr(12'h040, 32'h77, 1'b0, "R4 unlocked write");
        rd(12'h040, 32'h77, 1'b0, "R4 R3 back-to-back readback");

        wr(12'h014, 32'hFFFF_FFFF, 1'b1, "R7 write 0x014");
        rd(12'h014, 32'h0, 1'b0, "R7 0x014 kept");
        wr(12'h05C, 32'h1234, 1'b1, "R7 write scratch");
        rd(12'h05C, 32'h0, 1'b0, "R7 scratch kept");
        wr(12'h07C, 32'h0, 1'b1, "R7 write revision");
        rd(12'h07C, REV, 1'b0, "R7 revision kept");
        wr(12'h0E4, 32'h9, 1'b1, "R7 write 0x0E4");
        rd(12'h0E4, 32'h0, 1'b0, "R7 0x0E4 kept");

        wr(12'h0C0, 32'h0000_ABCD, 1'b0, "R8 write-only store");
        rd(12'h0C0, 32'h0000_ABCD, 1'b1, "R8 write-only read");

        rd(12'h1A8, 32'h0, 1'b1, "R9 read past end");
        wr(12'h1A8, 32'h5, 1'b1, "R9 write past end");
        rd(12'h1A8, 32'h0, 1'b1, "R9 still zero");
        rd(12'hFFC, 32'h0, 1'b1, "R9 top of space");
        rd(12'h1A4, 32'h0, 1'b0, "R9 last word valid");

        wr(12'h106, 32'h1, 1'b1, "R10 unaligned write");
        rd(12'h104, 32'hDEAD_BEEF, 1'b0, "R10 word untouched");
        rd(12'h102, 32'h0, 1'b1, "R10 unaligned read");

        wr(12'h000, 32'h0, 1'b0, "R4 relock");
        wr(12'h044, 32'h3, 1'b1, "R5 relocked write");
        rd(12'h044, 32'h0, 1'b0, "R5 relocked kept");
        idle(0);

        // R11: after an error response the flag is gone in the next cycle
        n_cmp++;
        if (bus_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 err held: actual err=%b expected err=0", bus_err);
        end
        idle(3);
        n_cmp++;
        if (tag_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3 missing responses: actual pending=%0d expected pending=0", tag_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule